// File: doc/BRIEF.md
# Sampled-Filter Sequencing Controller

This block is the master sequencer of a sampled-data filter. It idles until a one-cycle sample-timer pulse arrives. It then presents the most recent output word to a digital-to-analog converter over a shared bidirectional converter bus. After that it fires an analog-to-digital conversion and a convolution engine in the same cycle, and waits until both have finished. It then latches the fresh sample and the engine's result, and stores the sample in a circular sample memory at its write pointer.

The write pointer wraps at the memory depth. It is also handed to the convolution engine as that engine's base address. A bypass input replaces the filtered result with the raw sample, so the converters can be exercised with no arithmetic in the path. The converters, the engine and the memory all sit outside the block. The controller drives the bus only while it is talking to the DAC, and leaves it free for the ADC at all other times.

Top module: `sfc_seq`

## Requirements
- R1: While `rst_n` is low, and directly after it, the controller is idle. `dac_en_n`, `adc_sel_n` and `adc_go_n` are 1, `eng_start` and `mem_we` are 0, `eng_base` is 0, and the output word is 0.
- R2: A `tick` pulse seen while idle moves the controller into DAC output. There `dac_en_n` is 0 and `cbus` carries the output word for exactly HOLD_CYC (3) consecutive cycles.
- R3: The controller drives `cbus` only during DAC output. In every other state it releases the bus, so a value placed on it by the ADC is read back unaltered.
- R4: In the start state `adc_sel_n` and `adc_go_n` are 0 and `eng_start` is 1. The controller leaves this state only after a cycle in which `adc_busy` and `eng_busy` are both 1.
- R5: In the wait state `adc_go_n` returns to 1 and `eng_start` to 0, while `adc_sel_n` stays 0. The controller stays there until `adc_busy` and `eng_busy` are both 0.
- R6: The capture state lasts one cycle. It stores `cbus` as the input sample and, with `bypass` low, `eng_result` as the next output word.
- R7: With `bypass` high in the capture cycle, the next output word is the captured sample itself.
- R8: Capture is followed by exactly one memory-write cycle. In it `mem_we` is 1, `mem_addr` equals the write pointer and `mem_data` holds the captured sample. The controller is idle in the next cycle.
- R9: The write pointer, visible on `eng_base`, advances by one after each memory write and wraps from DEPTH-1 (15) to 0.
- R10: A `tick` pulse that arrives while the controller is not idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle sample-timer pulse |
| bypass | input | 1 | Route raw sample to the DAC |
| adc_busy | input | 1 | ADC conversion in progress |
| eng_busy | input | 1 | Convolution engine running |
| eng_result | input | DW | Engine output word |
| cbus | inout | DW | Shared converter data bus |
| dac_en_n | output | 1 | DAC latch enable, active low |
| adc_sel_n | output | 1 | ADC select, active low |
| adc_go_n | output | 1 | ADC conversion strobe, active low |
| eng_start | output | 1 | Convolution engine start |
| eng_base | output | AW | Write pointer given to the engine as base address |
| mem_we | output | 1 | Sample memory write enable |
| mem_addr | output | AW | Sample memory address |
| mem_data | output | DW | Sample memory write data |

## Verification
The bench builds the block with its default parameters: an 8-bit data word, a 16-entry memory and a 3-cycle DAC hold. It runs 22 sample frames, which is enough for the pointer to wrap once and then move on. The bench varies how quickly the engine accepts a start and how long it runs. As a result the ADC finishes first in some frames and the engine finishes first in others. Stray timer pulses are injected into DAC output, the start state and the wait state, and bypass is enabled for several frames, so that the raw sample path is exercised through a full DAC cycle.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_DAC   = 3'd1,
      S_START = 3'd2,
      S_WAIT  = 3'd3,
      S_CAPT  = 3'd4,
      S_MEMW  = 3'd5
   } seq_st_e;
endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
   import sfc_pkg::*;
#(
   parameter int HOLD_CYC = 3
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick_i,
   input  logic    adc_busy_i,
   input  logic    eng_busy_i,
   output seq_st_e st_o
);
   localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
   localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYC - 1);

   seq_st_e       st_q, st_d;
   logic [CW-1:0] hold_q, hold_d;

   always_comb begin
      st_d   = st_q;
      hold_d = hold_q;
      case (st_q)
         S_IDLE: if (tick_i) begin
            st_d   = S_DAC;
            hold_d = HOLD_LOAD;
         end
         S_DAC: begin
            if (hold_q == '0) st_d = S_START;
            else              hold_d = hold_q - 1'b1;
         end
         S_START: if (adc_busy_i && eng_busy_i) st_d = S_WAIT;
         S_WAIT:  if (!adc_busy_i && !eng_busy_i) st_d = S_CAPT;
         S_CAPT:  st_d = S_MEMW;
         S_MEMW:  st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         hold_q <= '0;
      end else begin
         st_q   <= st_d;
         hold_q <= hold_d;
      end
   end

   assign st_o = st_q;
endmodule

// File: rtl/sfc_wptr.sv
module sfc_wptr #(
   parameter int DEPTH = 16,
   parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   output logic [AW-1:0] ptr_o
);
   localparam bit POW2 = ((1 << AW) == DEPTH);

   logic [AW-1:0] ptr_q, ptr_inc;

   generate
      if (POW2) begin : g_natural_wrap
         assign ptr_inc = ptr_q + 1'b1;
      end else begin : g_compare_wrap
         assign ptr_inc = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_q <= '0;
      else if (adv_i) ptr_q <= ptr_inc;
   end

   assign ptr_o = ptr_q;
endmodule

// File: rtl/sfc_dpath.sv
module sfc_dpath #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_i,
   input  logic          bypass_i,
   input  logic [DW-1:0] bus_i,
   input  logic [DW-1:0] eng_res_i,
   output logic [DW-1:0] samp_o,
   output logic [DW-1:0] outw_o
);
   logic [DW-1:0] samp_q, outw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         samp_q <= '0;
         outw_q <= '0;
      end else if (cap_i) begin
         samp_q <= bus_i;
         outw_q <= bypass_i ? bus_i : eng_res_i;
      end
   end

   assign samp_o = samp_q;
   assign outw_o = outw_q;
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
   import sfc_pkg::*;
#(
   parameter int DW       = 8,
   parameter int DEPTH    = 16,
   parameter int HOLD_CYC = 3,
   parameter int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          bypass,
   input  logic          adc_busy,
   input  logic          eng_busy,
   input  logic [DW-1:0] eng_result,
   inout  wire  [DW-1:0] cbus,
   output logic          dac_en_n,
   output logic          adc_sel_n,
   output logic          adc_go_n,
   output logic          eng_start,
   output logic [AW-1:0] eng_base,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data
);
   generate
      if (DW < 2)       begin : g_bad_dw    $error("DW must be at least 2");       end
      if (DEPTH < 2)    begin : g_bad_depth $error("DEPTH must be at least 2");    end
      if (HOLD_CYC < 1) begin : g_bad_hold  $error("HOLD_CYC must be at least 1"); end
   endgenerate

   seq_st_e       st;
   logic [AW-1:0] wptr;
   logic [DW-1:0] samp, outw, bus_in;

   sfc_ctrl #(.HOLD_CYC(HOLD_CYC)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .adc_busy_i (adc_busy),
      .eng_busy_i (eng_busy),
      .st_o       (st)
   );

   sfc_wptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (st == S_MEMW),
      .ptr_o (wptr)
   );

   assign bus_in = cbus;

   sfc_dpath #(.DW(DW)) u_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_i     (st == S_CAPT),
      .bypass_i  (bypass),
      .bus_i     (bus_in),
      .eng_res_i (eng_result),
      .samp_o    (samp),
      .outw_o    (outw)
   );

   assign cbus      = (st == S_DAC) ? outw : {DW{1'bz}};
   assign dac_en_n  = (st != S_DAC);
   assign adc_sel_n = !((st == S_START) || (st == S_WAIT) || (st == S_CAPT));
   assign adc_go_n  = (st != S_START);
   assign eng_start = (st == S_START);
   assign mem_we    = (st == S_MEMW);
   assign mem_addr  = wptr;
   assign mem_data  = samp;
   assign eng_base  = wptr;
endmodule

// File: rtl/sfc_seq_chk.sv
module sfc_seq_chk #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          adc_busy,
   input logic          eng_busy,
   input logic          dac_en_n,
   input logic          adc_sel_n,
   input logic          adc_go_n,
   input logic          eng_start,
   input logic [AW-1:0] eng_base,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr
);
   // R3: the DAC and the ADC are never selected on the bus together
   a_r3_bus_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dac_en_n && !adc_sel_n));

   // R2: a DAC phase is longer than one cycle
   a_r2_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dac_en_n) |=> !dac_en_n);

   // R4: start is held until both units show they are busy
   a_r4_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && !(adc_busy && eng_busy)) |=> (eng_start && !adc_go_n));

   // R5: once both units are busy, start and strobe are released, select is kept
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start && adc_busy && eng_busy) |=> (!eng_start && adc_go_n && !adc_sel_n));

   // R8: a memory write lasts one cycle
   a_r8_one_write: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R9: the pointer advances by one, with wrap, after each write
   a_r9_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (eng_base == AW'($past(mem_addr) + 1'b1)));

   // R9: the pointer holds when no write takes place
   a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we |=> $stable(eng_base));
endmodule

bind sfc_seq sfc_seq_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adc_busy  (adc_busy),
   .eng_busy  (eng_busy),
   .dac_en_n  (dac_en_n),
   .adc_sel_n (adc_sel_n),
   .adc_go_n  (adc_go_n),
   .eng_start (eng_start),
   .eng_base  (eng_base),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/sim_sfc_seq.sv
`timescale 1ns/1ps
module sim_sfc_seq;
   localparam int DW = 8, DEPTH = 16, HOLD = 3, AW = 4;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bypass = 1'b0;
   logic adc_busy = 1'b0, eng_busy = 1'b0;
   logic [DW-1:0] eng_res = '0, adc_val = '0;
   wire  [DW-1:0] cbus;
   logic dac_en_n, adc_sel_n, adc_go_n, eng_start, mem_we;
   logic [AW-1:0] eng_base, mem_addr;
   logic [DW-1:0] mem_data;

   assign cbus = (!adc_sel_n && adc_go_n) ? adc_val : {DW{1'bz}};

   always #2.5 clk = ~clk;

   sfc_seq #(.DW(DW), .DEPTH(DEPTH), .HOLD_CYC(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bypass(bypass),
      .adc_busy(adc_busy), .eng_busy(eng_busy), .eng_result(eng_res),
      .cbus(cbus), .dac_en_n(dac_en_n), .adc_sel_n(adc_sel_n),
      .adc_go_n(adc_go_n), .eng_start(eng_start), .eng_base(eng_base),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
   );

   int total = 0, bad = 0;
   // reference model: 0 idle,1 dac,2 start,3 wait,4 capture,5 write
   int r_st = 0, r_cnt = 0, r_ptr = 0, r_in = 0, r_out = 0, dac_run = 0;
   bit r_byp = 0;
   // converter / engine models
   int adc_cnt = 0, eng_cnt = 0, eng_pend = 0, k_adc = 0, k_eng = 0;
   int adc_lat = 20, eng_lat = 10, eng_dly = 0;
   bit adc_armed = 0, eng_armed = 0;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step_ref();
      if (!rst_n) begin
         r_st = 0; r_cnt = 0; r_ptr = 0; r_in = 0; r_out = 0;
      end else begin
         case (r_st)
            0: if (tick) begin r_st = 1; r_cnt = HOLD - 1; end
            1: if (r_cnt == 0) r_st = 2; else r_cnt--;
            2: if (adc_busy && eng_busy) r_st = 3;
            3: if (!adc_busy && !eng_busy) r_st = 4;
            4: begin
               r_in  = int'(adc_val);
               r_out = bypass ? int'(adc_val) : int'(eng_res);
               r_byp = bypass;
               r_st  = 5;
            end
            default: begin r_ptr = (r_ptr + 1) % DEPTH; r_st = 0; end
         endcase
      end
   endtask

   task automatic compare();
      string tg;
      tg = (r_st == 0) ? "R1" : "R2";
      chk(tg,   int'(dac_en_n),  (r_st == 1) ? 0 : 1);
      chk("R4", int'(adc_go_n),  (r_st == 2) ? 0 : 1);
      chk("R4", int'(eng_start), (r_st == 2) ? 1 : 0);
      chk("R5", int'(adc_sel_n), (r_st >= 2 && r_st <= 4) ? 0 : 1);
      chk("R8", int'(mem_we),    (r_st == 5) ? 1 : 0);
      chk("R9", int'(eng_base),  r_ptr);
      if (r_st == 5) begin
         chk("R8", int'(mem_addr), r_ptr);
         chk("R6", int'(mem_data), r_in);
      end
      if (r_st == 1) chk(r_byp ? "R7" : "R6", int'(cbus), r_out);
      if (r_st >= 3 && r_st <= 4) chk("R3", int'(cbus), int'(adc_val));
      if (!dac_en_n) dac_run++;
      else if (dac_run != 0) begin
         chk("R2", dac_run, HOLD);
         dac_run = 0;
      end
   endtask

   task automatic step_models();
      if (adc_go_n) adc_armed = 0;
      if (adc_busy) begin
         adc_cnt--;
         if (adc_cnt == 0) adc_busy = 0;
      end else if (!adc_go_n && !adc_sel_n && !adc_armed) begin
         adc_armed = 1; adc_busy = 1; adc_cnt = adc_lat;
         k_adc++; adc_val = DW'((k_adc * 73 + 5) % 256);
      end
      if (!eng_start) eng_armed = 0;
      if (eng_pend > 0) begin
         eng_pend--;
         if (eng_pend == 0) begin eng_busy = 1; eng_cnt = eng_lat; end
      end else if (eng_busy) begin
         eng_cnt--;
         if (eng_cnt == 0) eng_busy = 0;
      end else if (eng_start && !eng_armed) begin
         eng_armed = 1;
         k_eng++; eng_res = DW'((k_eng * 29 + 200) % 256);
         if (eng_dly == 0) begin eng_busy = 1; eng_cnt = eng_lat; end
         else eng_pend = eng_dly;
      end
   endtask

   task automatic cycle();
      @(negedge clk);
      step_ref();
      compare();
      step_models();
   endtask

   // R10: stray ticks land in DAC output, start and wait states
   task automatic frames(input int n, input bit stray);
      for (int f = 0; f < n; f++) begin
         for (int c = 0; c < 80; c++) begin
            tick = (c == 0) || (stray && (c == 2 || c == 5 || c == 20));
            cycle();
         end
         tick = 1'b0;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      for (int i = 0; i < 4; i++) cycle();   // R1 checked in reset
      rst_n = 1'b1;
      cycle();
      chk("R1", int'(eng_base), 0);
      eng_dly = 0; eng_lat = 10; adc_lat = 20; bypass = 1'b0;
      frames(6, 1'b0);
      eng_dly = 3; eng_lat = 35;
      frames(4, 1'b0);
      eng_dly = 1; eng_lat = 6; bypass = 1'b1;   // R7
      frames(4, 1'b0);
      bypass = 1'b0; eng_dly = 2; eng_lat = 25;
      frames(8, 1'b1);                            // R10
      chk("R9", int'(eng_base), 22 % DEPTH);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule